// File: doc/BRIEF.md
# Three-wire serial EEPROM byte controller

This block is a hardware master for a small three-wire serial EEPROM that holds 128 byte-wide locations. It owns the device's chip select, serial clock and data-out lines, and it samples the device's data-in line. The host asks for a single byte to be read or written at a 7-bit address. The controller then builds every frame itself and answers with a one-cycle done strobe. For a read, the strobe comes with the read byte.

A write is never a single frame. The controller first unlocks the device. It then sends the write frame with its data byte and polls the device until it reports ready. Last, it locks the device again, so the device stays write-protected between host writes. The ready poll has an upper bound on its length. If the device never reports ready, the controller raises an error flag but still sends the lock frame before it returns to idle. All bus timing minimums are given in nanoseconds and are converted to whole system-clock cycles, rounding up.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset, cs_o, sck_o, busy_o, done_o and err_o are all 0.
- R2: A read request produces one chip-select cycle with exactly 18 clock pulses. dout_o carries a 10-bit frame MSB first on the first 10 rising edges: bits 9..7 = 3'b110 and bits 6..0 = the address, so the frame is 0x300 | addr.
- R3: For a read, din_i is sampled after each of clock pulses 11 to 18. The first sampled bit is the MSB. The assembled byte appears on rdata_o in the cycle where done_o is high.
- R4: A write produces four chip-select cycles, in this order: the unlock frame 0x260 (10 pulses); the write frame 0x280 | addr followed by the 8 data bits MSB first (18 pulses); a ready poll; and the lock frame 0x200 (10 pulses).
- R5: In a ready poll, the controller pulses the clock and samples din_i after each pulse. It drops chip select after the first pulse on which it samples 1.
- R6: Bus timing. sck_o is high only while cs_o is high. When cs_o rises, sck_o is low, and the first rising edge comes at least T_CSS_NS later. Each high phase lasts at least T_HIGH_NS. Each low phase between pulses lasts at least T_LOW_NS. dout_o is stable for at least T_SU_NS before each rising edge and stays stable while sck_o is high. Between chip-select cycles, cs_o stays low for at least T_CSH_NS. Every time is rounded up to whole clock cycles.
- R7: busy_o is high from the cycle after a request is accepted until the end of the transaction. req_i has no effect while busy_o is high: it starts no bus cycle and changes no data.
- R8: done_o is high for exactly one cycle per transaction, and busy_o is low in that cycle.
- R9: If a poll reaches MAX_POLL pulses without sampling 1, err_o goes high. The lock frame is still sent, and then done_o pulses. err_o stays 0 after a write whose poll succeeds. The next accepted request clears err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request, taken only when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Byte to write |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | One-cycle end-of-transaction strobe |
| rdata_o | output | DATA_W | Read byte, valid with done_o |
| err_o | output | 1 | Ready-poll timeout of the last write |
| cs_o | output | 1 | Device chip select |
| sck_o | output | 1 | Device serial clock |
| dout_o | output | 1 | Serial data to the device |
| din_i | input | 1 | Serial data from the device |

## Verification
The bench reads all 128 addresses from a device model preloaded with an arithmetic pattern. Because every address bit and many data patterns occur, a swapped, dropped or misordered frame or data bit shows up as a wrong byte or a wrong decoded frame. Writes use the all-zero, all-one and alternating bytes together with device busy lengths of zero to several pulses. These runs separate a correct poll length from off-by-one early or late exits, and they confirm that the lock frame always follows. A device that never reports ready tests the timeout path, and a request issued mid-transaction tests that busy requests are ignored. The model measures every pulse width, setup window and deselect gap against the rounded cycle minimums.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [2:0] {
    OP_READ,
    OP_WEN,
    OP_WRITE,
    OP_POLL,
    OP_WDS
  } op_e;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(longint clk_hz, longint ns);
    longint c;
    c = (ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mw_gap_timer.sv
module mw_gap_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign done_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= len_i - CW'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end

endmodule

// File: rtl/mw_bit_phy.sv
module mw_bit_phy #(
  parameter int SU_CYC = 1,
  parameter int HI_CYC = 1,
  parameter int LO_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_i,
  input  logic din_i,
  output logic sck_o,
  output logic dout_o,
  output logic done_o,
  output logic sample_o
);

  import mw_eeprom_pkg::*;

  localparam int MAXC = max2(SU_CYC, max2(HI_CYC, LO_CYC));
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {P_IDLE, P_SU, P_HI, P_LO} phase_e;

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= P_IDLE;
      cnt_q    <= '0;
      sck_o    <= 1'b0;
      dout_o   <= 1'b0;
      done_o   <= 1'b0;
      sample_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (ph_q)
        P_IDLE: if (start_i) begin
          dout_o <= bit_i;
          cnt_q  <= CW'(SU_CYC - 1);
          ph_q   <= P_SU;
        end
        P_SU: if (cnt_q == '0) begin
          sck_o <= 1'b1;
          cnt_q <= CW'(HI_CYC - 1);
          ph_q  <= P_HI;
        end else cnt_q <= cnt_q - CW'(1);
        P_HI: if (cnt_q == '0) begin
          sck_o <= 1'b0;
          cnt_q <= CW'(LO_CYC - 1);
          ph_q  <= P_LO;
        end else cnt_q <= cnt_q - CW'(1);
        P_LO: if (cnt_q == '0) begin
          // device output is taken once the full pulse has completed
          sample_o <= din_i;
          done_o   <= 1'b1;
          ph_q     <= P_IDLE;
        end else cnt_q <= cnt_q - CW'(1);
        default: ph_q <= P_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl #(
  parameter longint CLK_HZ    = 100_000_000,
  parameter int     ADDR_W    = 7,
  parameter int     DATA_W    = 8,
  parameter int     T_CSS_NS  = 50,
  parameter int     T_SU_NS   = 100,
  parameter int     T_HIGH_NS = 250,
  parameter int     T_LOW_NS  = 250,
  parameter int     T_CSH_NS  = 250,
  parameter int     MAX_POLL  = 16384
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              cs_o,
  output logic              sck_o,
  output logic              dout_o,
  input  logic              din_i
);

  import mw_eeprom_pkg::*;

  localparam int CSS_CYC = ns_to_cyc(CLK_HZ, T_CSS_NS);
  localparam int SU_CYC  = ns_to_cyc(CLK_HZ, T_SU_NS);
  localparam int HI_CYC  = ns_to_cyc(CLK_HZ, T_HIGH_NS);
  localparam int LO_CYC  = ns_to_cyc(CLK_HZ, T_LOW_NS);
  localparam int CSH_CYC = ns_to_cyc(CLK_HZ, T_CSH_NS);
  localparam int DCW     = $clog2(max2(CSS_CYC, CSH_CYC) + 1);
  localparam int FRAME_W = ADDR_W + 3;
  localparam int SH_W    = FRAME_W + DATA_W;
  localparam int BCW     = $clog2(SH_W + 1);
  localparam int PCW     = $clog2(MAX_POLL + 1);

  typedef enum logic [2:0] {S_IDLE, S_CSS, S_LAUNCH, S_WAIT, S_CSH} state_e;

  state_e            state_q;
  op_e               op_q, ld_op;
  logic [ADDR_W-1:0] addr_q, addr_sel;
  logic [DATA_W-1:0] wdata_q, wdata_sel, rx_q;
  logic [SH_W-1:0]   sh_q, ld_sh;
  logic [BCW-1:0]    bits_q, ld_bits;
  logic [PCW-1:0]    poll_q;
  logic              dly_start_q, dly_done;
  logic [DCW-1:0]    dly_len_q;
  logic              phy_done, phy_sample;
  logic              last_op;

  // command frames: start bit, two opcode bits, address field
  logic [FRAME_W-1:0] fr_rd, fr_wr, fr_wen, fr_wds;
  assign fr_rd  = {3'b110, addr_sel};
  assign fr_wr  = {3'b101, addr_sel};
  assign fr_wen = {3'b100, 2'b11, {(ADDR_W-2){1'b0}}};
  assign fr_wds = {3'b100, {ADDR_W{1'b0}}};

  assign addr_sel  = (state_q == S_IDLE) ? addr_i  : addr_q;
  assign wdata_sel = (state_q == S_IDLE) ? wdata_i : wdata_q;

  always_comb begin
    if (state_q == S_IDLE) ld_op = we_i ? OP_WEN : OP_READ;
    else begin
      case (op_q)
        OP_WEN:   ld_op = OP_WRITE;
        OP_WRITE: ld_op = OP_POLL;
        default:  ld_op = OP_WDS;
      endcase
    end
    case (ld_op)
      OP_READ:  begin ld_sh = {fr_rd,  {DATA_W{1'b0}}}; ld_bits = BCW'(SH_W);    end
      OP_WRITE: begin ld_sh = {fr_wr,  wdata_sel};      ld_bits = BCW'(SH_W);    end
      OP_WEN:   begin ld_sh = {fr_wen, {DATA_W{1'b0}}}; ld_bits = BCW'(FRAME_W); end
      OP_WDS:   begin ld_sh = {fr_wds, {DATA_W{1'b0}}}; ld_bits = BCW'(FRAME_W); end
      default:  begin ld_sh = '0;                       ld_bits = '0;            end
    endcase
  end

  assign last_op = (op_q == OP_READ) || (op_q == OP_WDS);

  mw_gap_timer #(.CW(DCW)) u_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (dly_start_q),
    .len_i   (dly_len_q),
    .done_o  (dly_done)
  );

  mw_bit_phy #(.SU_CYC(SU_CYC), .HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_phy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (state_q == S_LAUNCH),
    .bit_i    (sh_q[SH_W-1]),
    .din_i    (din_i),
    .sck_o    (sck_o),
    .dout_o   (dout_o),
    .done_o   (phy_done),
    .sample_o (phy_sample)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_q        <= OP_READ;
      addr_q      <= '0;
      wdata_q     <= '0;
      rx_q        <= '0;
      sh_q        <= '0;
      bits_q      <= '0;
      poll_q      <= '0;
      dly_start_q <= 1'b0;
      dly_len_q   <= '0;
      cs_o        <= 1'b0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
      err_o       <= 1'b0;
    end else begin
      dly_start_q <= 1'b0;
      done_o      <= 1'b0;
      case (state_q)
        S_IDLE: if (req_i) begin
          addr_q      <= addr_i;
          wdata_q     <= wdata_i;
          err_o       <= 1'b0;
          op_q        <= ld_op;
          sh_q        <= ld_sh;
          bits_q      <= ld_bits;
          poll_q      <= '0;
          cs_o        <= 1'b1;
          dly_start_q <= 1'b1;
          dly_len_q   <= DCW'(CSS_CYC);
          state_q     <= S_CSS;
        end
        S_CSS: if (dly_done) state_q <= S_LAUNCH;
        S_LAUNCH: state_q <= S_WAIT;
        S_WAIT: if (phy_done) begin
          if (op_q == OP_POLL) begin
            poll_q <= poll_q + PCW'(1);
            if (phy_sample || poll_q == PCW'(MAX_POLL - 1)) begin
              if (!phy_sample) err_o <= 1'b1;
              cs_o        <= 1'b0;
              dly_start_q <= 1'b1;
              dly_len_q   <= DCW'(CSH_CYC);
              state_q     <= S_CSH;
            end else state_q <= S_LAUNCH;
          end else begin
            sh_q   <= sh_q << 1;
            bits_q <= bits_q - BCW'(1);
            if (op_q == OP_READ && bits_q <= BCW'(DATA_W))
              rx_q <= {rx_q[DATA_W-2:0], phy_sample};
            if (bits_q == BCW'(1)) begin
              cs_o        <= 1'b0;
              dly_start_q <= 1'b1;
              dly_len_q   <= DCW'(CSH_CYC);
              state_q     <= S_CSH;
            end else state_q <= S_LAUNCH;
          end
        end
        S_CSH: if (dly_done) begin
          if (last_op) begin
            if (op_q == OP_READ) rdata_o <= rx_q;
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            op_q        <= ld_op;
            sh_q        <= ld_sh;
            bits_q      <= ld_bits;
            poll_q      <= '0;
            cs_o        <= 1'b1;
            dly_start_q <= 1'b1;
            dly_len_q   <= DCW'(CSS_CYC);
            state_q     <= S_CSS;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);

endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk #(
  parameter int HI_CYC = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic cs_o,
  input logic sck_o,
  input logic dout_o
);

  localparam int HCW = $clog2(HI_CYC + 2);

  logic [HCW-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          hi_cnt_q <= '0;
    else if (!sck_o)                      hi_cnt_q <= '0;
    else if (hi_cnt_q != HCW'(HI_CYC+1))  hi_cnt_q <= hi_cnt_q + HCW'(1);
  end

  AST_SCK_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> cs_o); // R6
  AST_CS_RISE_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> !sck_o); // R6
  AST_DOUT_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(dout_o)); // R6
  AST_SCK_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> (hi_cnt_q >= HCW'(HI_CYC))); // R6
  AST_CS_IMPLIES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> busy_o); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_ERR_RISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> busy_o); // R9

endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk #(.HI_CYC(HI_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_o (busy_o),
  .done_o (done_o),
  .err_o  (err_o),
  .cs_o   (cs_o),
  .sck_o  (sck_o),
  .dout_o (dout_o)
);

// File: tb/mw_eeprom_ctrl_bench.sv
`timescale 1ns/1ps
module mw_eeprom_ctrl_bench;

  // 125 MHz: 8 ns per cycle, so these round to 2,1,3,2,3 cycles
  localparam int CSS_C = 2, SU_C = 1, HI_C = 3, LO_C = 2, CSH_C = 3;
  localparam int MAXP  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic busy, done, err, cs, sck, dout;
  logic [7:0] rdata;
  logic din = 1'b0;

  always #4 clk = ~clk;

  mw_eeprom_ctrl #(
    .CLK_HZ(125_000_000), .ADDR_W(7), .DATA_W(8),
    .T_CSS_NS(16), .T_SU_NS(8), .T_HIGH_NS(24), .T_LOW_NS(16), .T_CSH_NS(24),
    .MAX_POLL(MAXP)
  ) u_mw_eeprom_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .err_o(err), .cs_o(cs), .sck_o(sck), .dout_o(dout), .din_i(din)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] mem [128];
  int  log_frame [512];
  int  log_bits  [512];
  bit  log_poll  [512];
  int  log_n = 0;
  int  tim_err = 0;
  int  busy_len = 0;
  bit  wen = 0, pend_poll = 0;
  bit  cs_p = 0, sck_p = 0, dout_p = 0, first = 0, poll_mode = 0;
  int  bitcnt = 0, frame = 0, wd = 0, dstab = 0, hi_cnt = 0, lo_cnt = 0;
  int  css_cnt = 0, low_cs = 100;

  always @(negedge clk) begin
    if (rst_n) begin
      dstab = (dout == dout_p) ? dstab + 1 : 1;
      if (cs && !cs_p) begin
        if (low_cs < CSH_C) tim_err++;
        if (sck) tim_err++;
        bitcnt = 0; frame = 0; wd = 0; first = 1; css_cnt = 0;
        poll_mode = pend_poll;
      end
      if (cs && !sck && first) css_cnt++;
      if (sck && !sck_p) begin
        if (!cs) tim_err++;
        if (first) begin if (css_cnt < CSS_C) tim_err++; end
        else if (lo_cnt < LO_C) tim_err++;
        if (dstab <= SU_C) tim_err++;
        first = 0;
        bitcnt++;
        hi_cnt = 1;
        if (poll_mode) din = (bitcnt > busy_len);
        else begin
          if (bitcnt <= 10) frame = (frame << 1) | int'(dout);
          else wd = (wd << 1) | int'(dout);
          if (bitcnt > 10 && bitcnt <= 18 && frame[9:7] == 3'b110)
            din = mem[frame[6:0]][18 - bitcnt];
          else din = 1'b0;
        end
      end else if (sck) hi_cnt++;
      if (!sck && sck_p) begin
        if (hi_cnt < HI_C) tim_err++;
        lo_cnt = 1;
      end else if (!sck) lo_cnt++;
      if (!cs && cs_p) begin
        log_frame[log_n % 512] = poll_mode ? 0 : frame;
        log_bits[log_n % 512]  = bitcnt;
        log_poll[log_n % 512]  = poll_mode;
        log_n++;
        if (poll_mode) pend_poll = 0;
        else if (bitcnt == 10 && frame == 'h260) wen = 1;
        else if (bitcnt == 10 && frame == 'h200) wen = 0;
        else if (bitcnt == 18 && frame[9:7] == 3'b101 && wen) begin
          mem[frame[6:0]] = wd[7:0];
          pend_poll = 1;
        end
        din = 1'b0;
        low_cs = 1;
      end else if (!cs && low_cs < 100) low_cs++;
      cs_p = cs; sck_p = sck; dout_p = dout;
    end
  end

  // ---------------- done monitor / watchdog ----------------
  int done_cyc = 0, cyc = 0;
  bit done_busy_bad = 0;
  always @(negedge clk) begin
    if (done) begin
      done_cyc++;
      if (busy) done_busy_bad = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic run_op(input bit w, input int a, input int d);
    @(negedge clk);
    req = 1; we = w; addr = 7'(a); wdata = 8'(d);
    @(negedge clk);
    req = 0;
    while (!done) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a << 2));
  endfunction

  task automatic check_write(input int a, input int d, input int p);
    int s, d0;
    bit to;
    s = log_n; d0 = done_cyc;
    busy_len = p;
    to = (p >= MAXP);
    run_op(1, a, d);
    @(negedge clk);
    chk(log_n - s == 4, "R4 cs cycles", log_n - s, 4);
    chk(log_frame[s % 512] == 'h260 && log_bits[s % 512] == 10, "R4 unlock frame",
        log_frame[s % 512], 'h260);
    chk(log_frame[(s+1) % 512] == ('h280 | a) && log_bits[(s+1) % 512] == 18,
        "R4 write frame", log_frame[(s+1) % 512], 'h280 | a);
    chk(log_poll[(s+2) % 512] && log_bits[(s+2) % 512] == (to ? MAXP : p + 1),
        to ? "R9 poll length" : "R5 poll length", log_bits[(s+2) % 512], to ? MAXP : p + 1);
    chk(log_frame[(s+3) % 512] == 'h200 && log_bits[(s+3) % 512] == 10, "R4 lock frame",
        log_frame[(s+3) % 512], 'h200);
    chk(mem[a] == 8'(d), "R4 stored byte", mem[a], d);
    chk(!wen, "R4 relocked", wen, 0);
    chk(err == to, "R9 err flag", err, to);
    chk(done_cyc - d0 == 1, "R8 done width", done_cyc - d0, 1);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    chk(!cs && !sck && !busy && !done && !err, "R1 reset outputs",
        {cs, sck, busy, done, err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!cs && !sck && !busy, "R1 after release", {cs, sck, busy}, 0);

    // full read sweep
    for (int a = 0; a < 128; a++) begin
      int s, d0;
      s = log_n; d0 = done_cyc;
      run_op(0, a, 0);
      chk(rdata == pat(a), "R3 read data", rdata, pat(a));
      @(negedge clk);
      chk(log_n - s == 1 && log_frame[s % 512] == ('h300 | a) && log_bits[s % 512] == 18,
          "R2 read frame", log_frame[s % 512], 'h300 | a);
      chk(done_cyc - d0 == 1 && !done_busy_bad, "R8 done pulse", done_cyc - d0, 1);
    end

    // writes with distinct data patterns and device busy lengths
    check_write(5,   'h00, 0);
    check_write(127, 'hFF, 1);
    check_write(0,   'hA5, 3);
    check_write(64,  'h5A, 7);
    check_write(85,  'h3C, 2);
    foreach (mem[i]) if (i == 5 || i == 127 || i == 0 || i == 64 || i == 85) begin
      run_op(0, i, 0);
      chk(rdata == mem[i], "R3 readback", rdata, mem[i]);
    end

    // request while busy is ignored
    begin
      int s;
      logic [7:0] keep;
      s = log_n; keep = mem[99];
      @(negedge clk);
      req = 1; we = 0; addr = 7'd17;
      @(negedge clk);
      req = 0;
      repeat (30) @(negedge clk);
      chk(busy, "R7 busy during read", busy, 1);
      req = 1; we = 1; addr = 7'd99; wdata = ~keep;
      @(negedge clk);
      req = 0;
      while (!done) @(negedge clk);
      chk(rdata == pat(17), "R7 first request result", rdata, pat(17));
      @(negedge clk);
      repeat (20) @(negedge clk);
      chk(log_n - s == 1, "R7 no extra bus cycle", log_n - s, 1);
      chk(mem[99] == keep && !busy, "R7 ignored write", mem[99], keep);
    end

    // poll timeout, then error cleared by next request
    check_write(33, 'h96, 1000);
    busy_len = 0;
    run_op(0, 2, 0);
    chk(!err, "R9 err cleared", err, 0);
    chk(rdata == pat(2), "R3 read after timeout", rdata, pat(2));

    chk(tim_err == 0, "R6 bus timing", tim_err, 0);
    chk(!done_busy_bad, "R8 busy low with done", done_busy_bad, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule